// File: doc/BRIEF.md
# Parity-Protected Buffer Memory

This block wraps a word-organised buffer memory. The memory holds a transmit area in the low word indices and a receive area directly above it. Next to every data word it keeps one parity bit for each byte lane, in a side array. Two requesters share the single access slot. The internal sequencer always wins. A host bus port (CPU or DMA) takes the slot only when the sequencer is idle, and it is held off through a ready signal otherwise.

Every write stores freshly computed parity for the lanes it touches. Every data read recomputes parity from the returned bytes and compares it with the stored bits. On a mismatch the block sends a one-cycle pulse to the system error handler, sets a sticky status flag and keeps the byte offset of the first failing word until software clears the flag.

For self-test, a test-enable input exposes the side array as a second host window in the upper half of the address space. In that window each parity bit can be read and written one byte at a time, so firmware can plant a wrong bit and then watch the checker react. A separate receive-write enable lets the host also fill the receive area.

Top module: `pbuf_ram`

## Requirements
- R1: Each byte lane's parity bit is the XOR of its eight data bits when `cfg_odd`=0, and the inverse of that XOR when `cfg_odd`=1. Every data write from either requester stores this bit for each lane it writes.
- R2: An accepted read returns its word one cycle later, with `h_rvalid` or `s_rvalid` high for exactly that cycle. Host byte offset 4*i addresses data word i.
- R3: While `s_req` is high, `h_ready` is low and no host access takes place. The sequencer access is performed in that cycle.
- R4: A host write to the data window changes only the data bytes and parity bits of the lanes whose `h_be` bit is set.
- R5: A data read whose stored parity differs from the recomputed parity in any lane drives `err_pulse` high for one cycle, two cycles after the read is accepted, and sets `err_flag` in the same cycle.
- R6: `err_addr` holds the byte offset (4*i) of the first failing word while `err_flag` stays set, and later errors do not replace it. `err_clr` clears the flag. If a clear and a new error coincide, the flag stays set and the new offset is captured.
- R7: With `cfg_test_en`=0, host reads at offsets 0x400 and above return zero, and host writes there leave all parity bits unchanged.
- R8: With `cfg_test_en`=1, offset 0x400+4*i holds, in byte lane b, the parity bit of data lane b of word i in bit 0, with bits 7:1 zero. A write there sets each enabled lane's parity bit to bit 0 of that byte. Reads of this window never raise an error.
- R9: A host write to a word index of `TX_WORDS` or above is ignored unless `cfg_rx_wr_en`=1. Sequencer writes reach every word.
- R10: A host data-window access to a word index at or beyond `TX_WORDS+RX_WORDS` reads zero, raises no error and writes nothing. In particular, it does not alias onto a lower word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_test_en | input | 1 | Exposes the parity window to the host |
| cfg_rx_wr_en | input | 1 | Allows host writes into the receive area |
| cfg_odd | input | 1 | Parity polarity: 1 odd, 0 even |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | ADDR_W | Host byte offset from the memory base |
| h_be | input | LANES | Host byte-lane enables |
| h_wdata | input | 8*LANES | Host write data |
| h_ready | output | 1 | Host access accepted this cycle |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | 8*LANES | Host read data |
| s_req | input | 1 | Sequencer access request |
| s_we | input | 1 | Sequencer write (1) or read (0) |
| s_idx | input | IW | Sequencer word index |
| s_wdata | input | 8*LANES | Sequencer write data |
| s_rvalid | output | 1 | Sequencer read data valid |
| s_rdata | output | 8*LANES | Sequencer read data |
| err_clr | input | 1 | Clears the error flag |
| err_pulse | output | 1 | One-cycle parity error event |
| err_flag | output | 1 | Sticky parity error status |
| err_addr | output | ADDR_W | Byte offset of the first failing word |

## Verification
The checker is driven with words whose byte lanes hold different parities, read back under both polarities. This separates a lane-order or polarity fault from a missing parity update. Parity bits planted through the test window in a single lane show whether errors are raised per lane and whether the first-failure offset survives a second error and a coincident clear. Collisions between the host and the sequencer, partial byte enables, receive-area writes with and without the enable, and accesses above the last word or into the locked window each have their own expected read-back. An arbitration or decode fault therefore shows up as wrong data rather than as a silent pass.

// File: rtl/pbr_pkg.sv
`timescale 1ns/1ps
package pbr_pkg;
   // parity bit of one byte lane; odd selects inverted polarity
   function automatic logic par_bit(input logic [7:0] b, input logic odd);
      return (^b) ^ odd;
   endfunction
endpackage

// File: rtl/pbr_arb.sv
`timescale 1ns/1ps
module pbr_arb #(
   parameter int ADDR_W   = 11,
   parameter int LANES    = 4,
   parameter int DEPTH    = 32,
   parameter int TX_WORDS = 16,
   parameter int IW       = 5
) (
   input  logic                 cfg_test_en,
   input  logic                 cfg_rx_wr_en,
   input  logic                 h_req,
   input  logic                 h_we,
   input  logic [ADDR_W-1:0]    h_addr,
   input  logic [LANES-1:0]     h_be,
   input  logic [8*LANES-1:0]   h_wdata,
   output logic                 h_ready,
   input  logic                 s_req,
   input  logic                 s_we,
   input  logic [IW-1:0]        s_idx,
   input  logic [8*LANES-1:0]   s_wdata,
   output logic [LANES-1:0]     op_dwe,
   output logic [LANES-1:0]     op_pwe,
   output logic                 op_hrd,
   output logic                 op_srd,
   output logic                 op_chk,
   output logic                 op_prd,
   output logic                 op_zero,
   output logic [IW-1:0]        op_idx,
   output logic [8*LANES-1:0]   op_wdata
);
   localparam int LB  = $clog2(LANES);
   localparam int HIW = ADDR_W - 1 - LB;

   logic [HIW-1:0] h_idx;
   logic           h_win, h_ok, h_rx, s_ok, win_open;

   assign h_idx    = h_addr[ADDR_W-2:LB];
   assign h_win    = h_addr[ADDR_W-1];
   assign h_ok     = {1'b0, h_idx} < (HIW+1)'(DEPTH);
   assign h_rx     = {1'b0, h_idx} >= (HIW+1)'(TX_WORDS);
   assign s_ok     = {1'b0, s_idx} < (IW+1)'(DEPTH);
   assign win_open = cfg_test_en && h_ok;
   assign h_ready  = !s_req;

   always_comb begin
      op_dwe   = '0;
      op_pwe   = '0;
      op_hrd   = 1'b0;
      op_srd   = 1'b0;
      op_chk   = 1'b0;
      op_prd   = 1'b0;
      op_zero  = 1'b0;
      op_idx   = s_idx;
      op_wdata = s_wdata;
      if (s_req) begin
         if (s_we) begin
            op_dwe = s_ok ? '1 : '0;
         end else begin
            op_srd  = 1'b1;
            op_chk  = s_ok;
            op_zero = !s_ok;
         end
      end else if (h_req) begin
         op_idx   = h_idx[IW-1:0];
         op_wdata = h_wdata;
         if (h_we) begin
            if (!h_win && h_ok && (!h_rx || cfg_rx_wr_en))
               op_dwe = h_be;
            else if (h_win && win_open)
               op_pwe = h_be;
         end else begin
            op_hrd = 1'b1;
            if (!h_win) begin
               op_chk  = h_ok;
               op_zero = !h_ok;
            end else begin
               op_prd  = win_open;
               op_zero = !win_open;
            end
         end
      end
   end
endmodule

// File: rtl/pbr_lane.sv
`timescale 1ns/1ps
module pbr_lane #(
   parameter int DEPTH = 32,
   parameter int IW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dwe,
   input  logic          pwe,
   input  logic          rd,
   input  logic [IW-1:0] idx,
   input  logic [7:0]    wbyte,
   input  logic          pbit,
   input  logic          odd,
   output logic [7:0]    rbyte,
   output logic          rpar
);
   import pbr_pkg::*;

   logic [7:0] dmem [DEPTH];
   logic       pmem [DEPTH];

   always_ff @(posedge clk) begin
      if (dwe) begin
         dmem[idx] <= wbyte;
         pmem[idx] <= par_bit(wbyte, odd);
      end else if (pwe) begin
         pmem[idx] <= pbit;
      end
      if (rd) begin
         rbyte <= dmem[idx];
         rpar  <= pmem[idx];
      end
   end

   // R4: one lane never takes a data write and a raw parity write together
   a_r4_one_write_kind: assert property (@(posedge clk) disable iff (!rst_n)
      !(dwe && pwe));
endmodule

// File: rtl/pbr_errcap.sv
`timescale 1ns/1ps
module pbr_errcap #(
   parameter int ADDR_W = 11,
   parameter int IW     = 5,
   parameter int LB     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [IW-1:0]     hit_idx,
   input  logic              clr,
   output logic              flag,
   output logic [ADDR_W-1:0] addr,
   output logic              pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         addr  <= '0;
         pulse <= 1'b0;
      end else begin
         pulse <= hit;
         flag  <= hit | (flag & ~clr);
         if (hit && (!flag || clr))
            addr <= ADDR_W'(hit_idx) << LB;
      end
   end

   a_r5_hit_raises: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (pulse && flag));
   a_r6_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> (flag && $stable(addr)));
   a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> !flag);
endmodule

// File: rtl/pbuf_ram.sv
`timescale 1ns/1ps
module pbuf_ram #(
   parameter int ADDR_W   = 11,
   parameter int LANES    = 4,
   parameter int TX_WORDS = 16,
   parameter int RX_WORDS = 16,
   parameter int DEPTH    = TX_WORDS + RX_WORDS,
   parameter int IW       = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_test_en,
   input  logic                cfg_rx_wr_en,
   input  logic                cfg_odd,
   input  logic                h_req,
   input  logic                h_we,
   input  logic [ADDR_W-1:0]   h_addr,
   input  logic [LANES-1:0]    h_be,
   input  logic [8*LANES-1:0]  h_wdata,
   output logic                h_ready,
   output logic                h_rvalid,
   output logic [8*LANES-1:0]  h_rdata,
   input  logic                s_req,
   input  logic                s_we,
   input  logic [IW-1:0]       s_idx,
   input  logic [8*LANES-1:0]  s_wdata,
   output logic                s_rvalid,
   output logic [8*LANES-1:0]  s_rdata,
   input  logic                err_clr,
   output logic                err_pulse,
   output logic                err_flag,
   output logic [ADDR_W-1:0]   err_addr
);
   import pbr_pkg::*;

   localparam int LB = $clog2(LANES);
   localparam int DW = 8 * LANES;

   initial begin
      assert ((1 << LB) == LANES) else $error("LANES must be a power of two");
      assert (DEPTH >= 2 && TX_WORDS >= 1 && RX_WORDS >= 1) else $error("bad area sizes");
      assert (DEPTH == TX_WORDS + RX_WORDS) else $error("DEPTH must cover both areas");
      assert (DEPTH * LANES <= (1 << (ADDR_W - 1))) else $error("areas exceed the data window");
   end

   logic [LANES-1:0] op_dwe, op_pwe, lane_bad, rd_par;
   logic             op_hrd, op_srd, op_chk, op_prd, op_zero, lane_rd;
   logic [IW-1:0]    op_idx, rd_idx_q;
   logic [DW-1:0]    op_wdata, rd_data, par_word, rd_word;
   logic             rd_h_q, rd_s_q, rd_chk_q, rd_prd_q, rd_zero_q, err_hit;

   pbr_arb #(.ADDR_W(ADDR_W), .LANES(LANES), .DEPTH(DEPTH), .TX_WORDS(TX_WORDS), .IW(IW)) u_arb (
      .cfg_test_en (cfg_test_en),
      .cfg_rx_wr_en(cfg_rx_wr_en),
      .h_req       (h_req),
      .h_we        (h_we),
      .h_addr      (h_addr),
      .h_be        (h_be),
      .h_wdata     (h_wdata),
      .h_ready     (h_ready),
      .s_req       (s_req),
      .s_we        (s_we),
      .s_idx       (s_idx),
      .s_wdata     (s_wdata),
      .op_dwe      (op_dwe),
      .op_pwe      (op_pwe),
      .op_hrd      (op_hrd),
      .op_srd      (op_srd),
      .op_chk      (op_chk),
      .op_prd      (op_prd),
      .op_zero     (op_zero),
      .op_idx      (op_idx),
      .op_wdata    (op_wdata)
   );

   assign lane_rd = (op_hrd || op_srd) && !op_zero;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      pbr_lane #(.DEPTH(DEPTH), .IW(IW)) u_lane (
         .clk  (clk),
         .rst_n(rst_n),
         .dwe  (op_dwe[g]),
         .pwe  (op_pwe[g]),
         .rd   (lane_rd),
         .idx  (op_idx),
         .wbyte(op_wdata[8*g +: 8]),
         .pbit (op_wdata[8*g]),
         .odd  (cfg_odd),
         .rbyte(rd_data[8*g +: 8]),
         .rpar (rd_par[g])
      );
      assign par_word[8*g +: 8] = {7'd0, rd_par[g]};
      assign lane_bad[g]        = rd_par[g] != par_bit(rd_data[8*g +: 8], cfg_odd);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_h_q    <= 1'b0;
         rd_s_q    <= 1'b0;
         rd_chk_q  <= 1'b0;
         rd_prd_q  <= 1'b0;
         rd_zero_q <= 1'b0;
         rd_idx_q  <= '0;
      end else begin
         rd_h_q    <= op_hrd;
         rd_s_q    <= op_srd;
         rd_chk_q  <= op_chk;
         rd_prd_q  <= op_prd;
         rd_zero_q <= op_zero;
         rd_idx_q  <= op_idx;
      end
   end

   assign rd_word  = rd_zero_q ? '0 : (rd_prd_q ? par_word : rd_data);
   assign h_rvalid = rd_h_q;
   assign h_rdata  = rd_word;
   assign s_rvalid = rd_s_q;
   assign s_rdata  = rd_word;
   assign err_hit  = rd_chk_q && (|lane_bad);

   pbr_errcap #(.ADDR_W(ADDR_W), .IW(IW), .LB(LB)) u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (err_hit),
      .hit_idx(rd_idx_q),
      .clr    (err_clr),
      .flag   (err_flag),
      .addr   (err_addr),
      .pulse  (err_pulse)
   );

   a_r2_seq_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      op_srd |=> s_rvalid);
   a_r2_host_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      op_hrd |=> h_rvalid);
   a_r3_seq_first: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req && h_req) |=> !h_rvalid);
   a_r7_window_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_test_en |-> (op_pwe == '0));
   a_r8_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      op_prd |=> !err_hit);
endmodule

// File: tb/pbuf_ram_tb.sv
`timescale 1ns/1ps
module pbuf_ram_tb;
   localparam int TXW = 16;
   localparam int D   = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        test_en = 0, rx_en = 0, odd = 0, clr_i = 0;
   logic        h_req = 0, h_we = 0, s_req = 0, s_we = 0;
   logic [10:0] h_addr = '0;
   logic [3:0]  h_be = '0;
   logic [31:0] h_wdata = '0, s_wdata = '0;
   logic [4:0]  s_idx = '0;
   logic        h_ready, h_rvalid, s_rvalid, err_pulse, err_flag;
   logic [31:0] h_rdata, s_rdata;
   logic [10:0] err_addr;

   pbuf_ram u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_test_en(test_en), .cfg_rx_wr_en(rx_en), .cfg_odd(odd),
      .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_be(h_be), .h_wdata(h_wdata),
      .h_ready(h_ready), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
      .s_req(s_req), .s_we(s_we), .s_idx(s_idx), .s_wdata(s_wdata),
      .s_rvalid(s_rvalid), .s_rdata(s_rdata),
      .err_clr(clr_i), .err_pulse(err_pulse), .err_flag(err_flag), .err_addr(err_addr)
   );

   int total = 0, bad = 0;
   logic [7:0] mb [D][4];
   bit         mp [D][4];
   bit         e_flag = 0, hit_now = 0;
   int         e_addr = 0, hit_idx = 0;

   function automatic bit pf(input logic [7:0] b, input bit o);
      return (^b) ^ o;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] dword(input int i);
      return {mb[i][3], mb[i][2], mb[i][1], mb[i][0]};
   endfunction

   function automatic bit mism(input int i);
      bit m = 0;
      for (int b = 0; b < 4; b++) if (mp[i][b] != pf(mb[i][b], odd)) m = 1;
      return m;
   endfunction

   // one clock of stimulus plus the model's prediction for the following cycle
   task automatic cyc(input bit sr, input bit swe, input int sidx, input logic [31:0] swd,
                      input bit hr, input bit hwe, input int haddr, input logic [3:0] hbe,
                      input logic [31:0] hwd, input bit clr, input string tag);
      bit n_flag, n_pulse, n_hv = 0, n_sv = 0, n_hit = 0;
      int n_addr, n_hidx = 0;
      logic [31:0] n_word = '0;
      s_req = sr; s_we = swe; s_idx = sidx[4:0]; s_wdata = swd;
      h_req = hr; h_we = hwe; h_addr = haddr[10:0]; h_be = hbe; h_wdata = hwd; clr_i = clr;
      #1 chk("R3", "h_ready", {31'd0, h_ready}, {31'd0, !sr});
      n_pulse = hit_now;
      n_flag  = hit_now || (e_flag && !clr);
      n_addr  = e_addr;
      if (hit_now && (!e_flag || clr)) n_addr = hit_idx * 4;
      if (sr) begin
         if (swe) begin
            if (sidx < D) for (int b = 0; b < 4; b++) begin
               mb[sidx][b] = swd[8*b +: 8]; mp[sidx][b] = pf(swd[8*b +: 8], odd);
            end
         end else begin
            n_sv = 1;
            if (sidx < D) begin n_word = dword(sidx); n_hit = mism(sidx); n_hidx = sidx; end
         end
      end else if (hr) begin
         int  hi  = (haddr >> 2) & 255;
         bit  win = haddr >= 'h400;
         bit  ok  = hi < D;
         if (hwe) begin
            if (!win && ok && (hi < TXW || rx_en)) begin
               for (int b = 0; b < 4; b++) if (hbe[b]) begin
                  mb[hi][b] = hwd[8*b +: 8]; mp[hi][b] = pf(hwd[8*b +: 8], odd);
               end
            end else if (win && test_en && ok) begin
               for (int b = 0; b < 4; b++) if (hbe[b]) mp[hi][b] = hwd[8*b];
            end
         end else begin
            n_hv = 1;
            if (!win && ok) begin n_word = dword(hi); n_hit = mism(hi); n_hidx = hi; end
            else if (win && test_en && ok)
               for (int b = 0; b < 4; b++) n_word[8*b +: 8] = {7'd0, mp[hi][b]};
         end
      end
      @(posedge clk);
      @(negedge clk);
      chk(tag, "h_rvalid", {31'd0, h_rvalid}, {31'd0, n_hv});
      if (n_hv) chk(tag, "h_rdata", h_rdata, n_word);
      chk(tag, "s_rvalid", {31'd0, s_rvalid}, {31'd0, n_sv});
      if (n_sv) chk(tag, "s_rdata", s_rdata, n_word);
      chk("R5", "err_pulse", {31'd0, err_pulse}, {31'd0, n_pulse});
      chk("R6", "err_flag", {31'd0, err_flag}, {31'd0, n_flag});
      chk("R6", "err_addr", {21'd0, err_addr}, n_addr);
      e_flag = n_flag; e_addr = n_addr; hit_now = n_hit; hit_idx = n_hidx;
   endtask

   task automatic sw(input int i, input logic [31:0] v, input string t); cyc(1,1,i,v,0,0,0,0,0,0,t); endtask
   task automatic srd(input int i, input string t);                      cyc(1,0,i,0,0,0,0,0,0,0,t); endtask
   task automatic hw(input int a, input logic [3:0] be, input logic [31:0] v, input string t);
      cyc(0,0,0,0,1,1,a,be,v,0,t);
   endtask
   task automatic hrd(input int a, input string t);                      cyc(0,0,0,0,1,0,a,0,0,0,t); endtask
   task automatic idle(input bit c, input string t);                     cyc(0,0,0,0,0,0,0,0,0,c,t); endtask

   bit done = 0;
   initial begin
      #2000000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog run did not complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R2", "reset h_rvalid", {31'd0, h_rvalid}, 0);
      chk("R2", "reset s_rvalid", {31'd0, s_rvalid}, 0);
      chk("R5", "reset err_flag", {31'd0, err_flag}, 0);
      chk("R6", "reset err_addr", {21'd0, err_addr}, 0);
      rst_n = 1'b1;
      // R1: fill every word through the sequencer with mixed-parity bytes
      for (int i = 0; i < D; i++) begin
         logic [31:0] v = 32'h9E3779B9 * (i + 1);
         sw(i, v ^ {i[7:0], 8'h5A, i[7:0], 8'h03}, "R1");
      end
      // R2: reads from both requesters
      srd(0, "R2"); srd(17, "R2"); hrd('h004, "R2"); hrd('h07C, "R2");
      // R1: parity window shows even parity per lane
      test_en = 1;
      hrd('h400, "R1"); hrd('h404, "R1"); hrd('h43C, "R1");
      // R3: sequencer read collides with host write, host write must not land
      cyc(1,0,4,0, 1,1,'h008,4'hF,32'hDEADBEEF, 0, "R3");
      hrd('h008, "R3");
      // R4: partial byte enables
      hw('h00C, 4'b0101, 32'h11223344, "R4");
      hrd('h00C, "R4"); hrd('h40C, "R4");
      // R9: receive area guarded by the enable
      hw('h050, 4'hF, 32'hCAFEF00D, "R9"); hrd('h050, "R9");
      rx_en = 1;
      hw('h050, 4'hF, 32'hCAFEF00D, "R9"); hrd('h050, "R9");
      rx_en = 0;
      // R7: locked window reads zero, writes dropped
      test_en = 0;
      hrd('h404, "R7");
      hw('h404, 4'hF, 32'h01010101 ^ {7'd0, mp[1][3], 7'd0, mp[1][2], 7'd0, mp[1][1], 7'd0, mp[1][0]}, "R7");
      test_en = 1;
      hrd('h404, "R7"); hrd('h004, "R7"); idle(0, "R7");
      // R10: above the last word
      hrd('h0A0, "R10"); hw('h0A0, 4'hF, 32'h0BADC0DE, "R10"); hrd('h020, "R10"); idle(0, "R10");
      // R8 / R5: plant a wrong bit in word 2 lane 0
      hw('h408, 4'b0001, {31'd0, !mp[2][0]}, "R8");
      hrd('h408, "R8"); idle(0, "R8");
      srd(2, "R5"); idle(0, "R5"); idle(0, "R5");
      // R6: second error keeps first offset
      hw('h414, 4'b1000, {7'd0, !mp[5][3], 24'd0}, "R8");
      hrd('h014, "R6"); idle(0, "R6"); idle(0, "R6");
      idle(1, "R6"); idle(0, "R6");
      // R6: clear coincides with new error
      srd(5, "R6"); idle(1, "R6"); idle(0, "R6");
      idle(1, "R6"); idle(0, "R6");
      // R1: odd polarity
      odd = 1;
      sw(6, 32'h00FF0180, "R1"); hrd('h418, "R1"); srd(6, "R1"); idle(0, "R1"); idle(0, "R1");
      // R5: word written under even polarity now checked as odd
      hrd('h01C, "R5"); idle(0, "R5"); idle(1, "R5"); idle(0, "R5");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule